// File: doc/BRIEF.md
# Serial Line State Detector

The detector sits behind a receiver that delivers 5-bit code symbols two at a time, together with a signal-detect level from the optical front end. Each cycle in which a symbol pair is presented, the block sorts the pair into one of a few patterns and counts runs of them. Long enough runs move the link into a known line state: quiet, halt, master or noise. A dropped signal-detect forces the no-signal state. When the traffic stops supporting the current known state, the block falls back to an unknown state.

Every state entry is remembered in an 8-bit sticky history register. Hardware only ever sets its bits, and software clears them by writing zeros. A mask register beside it selects which history bits drive a single interrupt flag. A noise countdown counter, loaded by software, decrements on each invalid symbol and raises its own history bit when it sits at zero. A small address/data port gives access to the history, mask, counter and current state.

Top module: `line_state_watch`

## Requirements
- R1: Quiet state (state code 2, history bit 1) is entered on the eighth consecutive presented pair whose two symbols are both 00000. Any other presented pair restarts the run. Cycles with no pair presented do not break the run.
- R2: Halt state (code 3, history bit 2) is entered on the eighth consecutive pair whose two symbols are both 00100.
- R3: Master state (code 4, history bit 3) is entered on the eighth consecutive pair whose first symbol is 00100 and whose second symbol is 00000.
- R4: A noise event is a received symbol equal to 00001, 00010, 00011, 00101, 00110, 01000, 01100 or 10000. Noise state (code 5, history bit 4) is entered once consecutive noisy pairs have carried sixteen events. A pair with no noise symbol restarts the count.
- R5: While signal detect is low, the state becomes no-signal (code 1) at the next edge, and history bit 0 is set on every such edge.
- R6: The history register sits at address 0. Hardware only sets its bits. A write clears the bits written as 0 and leaves the bits written as 1 unchanged. A hardware set in the same cycle wins over the clear.
- R7: History bit 6 is set whenever the line state changes.
- R8: The state becomes unknown (code 0) and history bit 7 is set in two cases: when a presented pair fails to sustain a quiet, halt, master or noise state, or when signal detect returns while in no-signal.
- R9: The mask register sits at address 1, is read/write and resets to 0. The current state code is readable at address 3.
- R10: The noise counter sits at address 2. A write loads it and, if the value is 1 or more, clears history bit 5. Each noise event decrements it, saturating at 0. History bit 5 is set on every edge where the counter's new value is 0.
- R11: The interrupt flag is high when any history bit and its matching mask bit are both 1.
- R12: After reset, history reads 0x20, mask 0, counter 0 and state 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sigDetect | input | 1 | Optical signal present |
| pairValid | input | 1 | A symbol pair is presented this cycle |
| symFirst | input | 5 | Earlier symbol of the pair |
| symSecond | input | 5 | Later symbol of the pair |
| regAddr | input | 2 | Register select: 0 history, 1 mask, 2 noise counter, 3 state |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data of the selected register |
| intFlag | output | 1 | Masked summary of the history |

## Verification
The bench builds the block with its default values: runs of eight pattern pairs, sixteen noise events for noise state, and an 8-bit counter. With these values every state entry can be reached in a few dozen cycles, along with the one-short boundary just before it. Loading the counter with small values (3, 5, 0) lets two-event noisy pairs drive it to zero and saturate there well before the noise state is reached. That order exercises the zero flag, its persistence through a history write and its clearing by a reload.

// File: rtl/lsd_pkg.sv
package lsd_pkg;

  typedef enum logic [2:0] {
    LS_UNKNOWN = 3'd0,
    LS_NOSIG   = 3'd1,
    LS_QUIET   = 3'd2,
    LS_HALT    = 3'd3,
    LS_MASTER  = 3'd4,
    LS_NOISE   = 3'd5
  } lineState_e;

  typedef enum logic [1:0] {
    PAT_NONE,
    PAT_QUIET,
    PAT_HALT,
    PAT_MASTER
  } pairPat_e;

  typedef struct packed {
    logic       setNoSig;
    logic       setQuiet;
    logic       setHalt;
    logic       setMaster;
    logic       setNoise;
    logic       setChange;
    logic       setUnknown;
    logic [1:0] noiseEvents;
  } strobes_t;

  localparam logic [4:0] SYM_QUIET = 5'b00000;
  localparam logic [4:0] SYM_HALT  = 5'b00100;

  localparam logic [1:0] ADDR_HIST  = 2'd0;
  localparam logic [1:0] ADDR_MASK  = 2'd1;
  localparam logic [1:0] ADDR_CNT   = 2'd2;
  localparam logic [1:0] ADDR_STATE = 2'd3;

  localparam int HB_NOSIG   = 0;
  localparam int HB_QUIET   = 1;
  localparam int HB_HALT    = 2;
  localparam int HB_MASTER  = 3;
  localparam int HB_NOISE   = 4;
  localparam int HB_ZERO    = 5;
  localparam int HB_CHANGE  = 6;
  localparam int HB_UNKNOWN = 7;

endpackage

// File: rtl/lsd_symcheck.sv
module lsd_symcheck (
  input  logic [4:0] sym,
  output logic       isNoise
);
  // Only the eight codes outside the data and control sets count as noise.
  always_comb begin
    case (sym)
      5'b00001, 5'b00010, 5'b00011, 5'b00101,
      5'b00110, 5'b01000, 5'b01100, 5'b10000: isNoise = 1'b1;
      default:                                isNoise = 1'b0;
    endcase
  end
endmodule

// File: rtl/lsd_ctrl.sv
module lsd_ctrl
  import lsd_pkg::*;
#(
  parameter int RUN_LEN   = 8,
  parameter int NOISE_LEN = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sigDetect,
  input  logic       pairValid,
  input  logic [4:0] symFirst,
  input  logic [4:0] symSecond,
  output strobes_t   strb,
  output lineState_e curState
);
  localparam int RUN_W   = $clog2(RUN_LEN + 1);
  localparam int NOISE_W = $clog2(NOISE_LEN + 1);
  localparam logic [RUN_W-1:0]   RUN_MAX   = RUN_W'(RUN_LEN);
  localparam logic [NOISE_W:0]   NOISE_MAX = (NOISE_W + 1)'(NOISE_LEN);

  logic [1:0][4:0] syms;
  logic [1:0]      symNoise;
  assign syms = {symSecond, symFirst};

  for (genvar i = 0; i < 2; i++) begin : g_sym
    lsd_symcheck u_chk (.sym(syms[i]), .isNoise(symNoise[i]));
  end

  pairPat_e            pairPat, runPat, runPatNext;
  logic [RUN_W-1:0]    runCnt, runCntNext;
  logic [NOISE_W-1:0]  noiseRun, noiseRunNext;
  logic [NOISE_W:0]    noiseSum;
  logic [1:0]          nEv;
  lineState_e          stateNext;
  logic                sustain;

  assign nEv      = {1'b0, symNoise[0]} + {1'b0, symNoise[1]};
  assign noiseSum = {1'b0, noiseRun} + (NOISE_W + 1)'(nEv);

  always_comb begin
    if (symFirst == SYM_QUIET && symSecond == SYM_QUIET)     pairPat = PAT_QUIET;
    else if (symFirst == SYM_HALT && symSecond == SYM_HALT)  pairPat = PAT_HALT;
    else if (symFirst == SYM_HALT && symSecond == SYM_QUIET) pairPat = PAT_MASTER;
    else                                                     pairPat = PAT_NONE;
  end

  always_comb begin
    case (curState)
      LS_QUIET:  sustain = (pairPat == PAT_QUIET);
      LS_HALT:   sustain = (pairPat == PAT_HALT);
      LS_MASTER: sustain = (pairPat == PAT_MASTER);
      LS_NOISE:  sustain = (nEv != 2'd0);
      default:   sustain = 1'b1;
    endcase
  end

  always_comb begin
    runPatNext   = runPat;
    runCntNext   = runCnt;
    noiseRunNext = noiseRun;
    stateNext    = curState;
    if (!sigDetect) begin
      runPatNext   = PAT_NONE;
      runCntNext   = '0;
      noiseRunNext = '0;
      stateNext    = LS_NOSIG;
    end else begin
      if (curState == LS_NOSIG) stateNext = LS_UNKNOWN;
      if (pairValid) begin
        if (pairPat == PAT_NONE) begin
          runPatNext = PAT_NONE;
          runCntNext = '0;
        end else if (pairPat == runPat && runCnt != '0) begin
          runCntNext = (runCnt >= RUN_MAX) ? runCnt : runCnt + 1'b1;
        end else begin
          runPatNext = pairPat;
          runCntNext = RUN_W'(1);
        end
        if (nEv == 2'd0)             noiseRunNext = '0;
        else if (noiseSum >= NOISE_MAX) noiseRunNext = NOISE_W'(NOISE_LEN);
        else                         noiseRunNext = noiseSum[NOISE_W-1:0];
        if (!sustain) stateNext = LS_UNKNOWN;
        if (runCntNext == RUN_MAX) begin
          case (runPatNext)
            PAT_QUIET:  stateNext = LS_QUIET;
            PAT_HALT:   stateNext = LS_HALT;
            PAT_MASTER: stateNext = LS_MASTER;
            default:    ;
          endcase
        end
        if ({1'b0, noiseRunNext} == NOISE_MAX) stateNext = LS_NOISE;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runPat   <= PAT_NONE;
      runCnt   <= '0;
      noiseRun <= '0;
      curState <= LS_UNKNOWN;
    end else begin
      runPat   <= runPatNext;
      runCnt   <= runCntNext;
      noiseRun <= noiseRunNext;
      curState <= stateNext;
    end
  end

  always_comb begin
    strb.setNoSig    = !sigDetect;
    strb.setQuiet    = (stateNext == LS_QUIET)   && (curState != LS_QUIET);
    strb.setHalt     = (stateNext == LS_HALT)    && (curState != LS_HALT);
    strb.setMaster   = (stateNext == LS_MASTER)  && (curState != LS_MASTER);
    strb.setNoise    = (stateNext == LS_NOISE)   && (curState != LS_NOISE);
    strb.setChange   = (stateNext != curState);
    strb.setUnknown  = (stateNext == LS_UNKNOWN) && (curState != LS_UNKNOWN);
    strb.noiseEvents = (pairValid && sigDetect) ? nEv : 2'd0;
  end

  // R5: a low signal detect always lands in the no-signal state
  a_r5_nosig_state: assert property (@(posedge clk) disable iff (!rstN)
    !sigDetect |=> curState == LS_NOSIG);

  // R4: noise state is only reached on a presented pair with signal present
  a_r4_noise_entry: assert property (@(posedge clk) disable iff (!rstN)
    (curState == LS_NOISE && $past(curState) != LS_NOISE) |-> $past(pairValid && sigDetect));

endmodule

// File: rtl/lsd_dpath.sv
module lsd_dpath
  import lsd_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  strobes_t   strb,
  input  lineState_e curState,
  input  logic [1:0] regAddr,
  input  logic       regWrEn,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  output logic       intFlag
);
  logic [7:0]       hist, histNext, mask, hwSet;
  logic [CNT_W-1:0] noiseCnt, cntNext, evAmt;
  logic             histWr, maskWr, cntWr;

  assign histWr = regWrEn && (regAddr == ADDR_HIST);
  assign maskWr = regWrEn && (regAddr == ADDR_MASK);
  assign cntWr  = regWrEn && (regAddr == ADDR_CNT);
  assign evAmt  = CNT_W'(strb.noiseEvents);

  always_comb begin
    if (cntWr)                cntNext = regWrData[CNT_W-1:0];
    else if (evAmt >= noiseCnt) cntNext = '0;
    else                      cntNext = noiseCnt - evAmt;
  end

  always_comb begin
    hwSet = '0;
    hwSet[HB_NOSIG]   = strb.setNoSig;
    hwSet[HB_QUIET]   = strb.setQuiet;
    hwSet[HB_HALT]    = strb.setHalt;
    hwSet[HB_MASTER]  = strb.setMaster;
    hwSet[HB_NOISE]   = strb.setNoise;
    hwSet[HB_ZERO]    = (cntNext == '0);
    hwSet[HB_CHANGE]  = strb.setChange;
    hwSet[HB_UNKNOWN] = strb.setUnknown;
    histNext = histWr ? (hist & regWrData) : hist;
    if (cntWr && cntNext != '0) histNext[HB_ZERO] = 1'b0;
    histNext = histNext | hwSet;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hist     <= 8'h20;
      mask     <= '0;
      noiseCnt <= '0;
    end else begin
      hist     <= histNext;
      noiseCnt <= cntNext;
      if (maskWr) mask <= regWrData;
    end
  end

  always_comb begin
    case (regAddr)
      ADDR_HIST: regRdData = hist;
      ADDR_MASK: regRdData = mask;
      ADDR_CNT:  regRdData = 8'(noiseCnt);
      default:   regRdData = 8'(curState);
    endcase
  end

  assign intFlag = |(hist & mask);

  // R6: without a history or counter write, no history bit ever falls
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && (regAddr == ADDR_HIST || regAddr == ADDR_CNT))
      |=> ((hist & $past(hist)) == $past(hist)));

  // R10: an empty noise counter is always flagged
  a_r10_zero_flag: assert property (@(posedge clk) disable iff (!rstN)
    (noiseCnt == '0) |-> hist[HB_ZERO]);

  // R7: any move of the line state leaves the change bit set
  a_r7_change_bit: assert property (@(posedge clk) disable iff (!rstN)
    (curState != $past(curState)) |-> hist[HB_CHANGE]);

  // R8: falling into the unknown state leaves its bit set
  a_r8_unknown_bit: assert property (@(posedge clk) disable iff (!rstN)
    (curState == LS_UNKNOWN && $past(curState) != LS_UNKNOWN) |-> hist[HB_UNKNOWN]);

endmodule

// File: rtl/line_state_watch.sv
module line_state_watch
  import lsd_pkg::*;
#(
  parameter int RUN_LEN   = 8,
  parameter int NOISE_LEN = 16,
  parameter int CNT_W     = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sigDetect,
  input  logic       pairValid,
  input  logic [4:0] symFirst,
  input  logic [4:0] symSecond,
  input  logic [1:0] regAddr,
  input  logic       regWrEn,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  output logic       intFlag
);
  strobes_t   strb;
  lineState_e curState;

  lsd_ctrl #(.RUN_LEN(RUN_LEN), .NOISE_LEN(NOISE_LEN)) u_ctrl (
    .clk(clk), .rstN(rstN), .sigDetect(sigDetect), .pairValid(pairValid),
    .symFirst(symFirst), .symSecond(symSecond), .strb(strb), .curState(curState)
  );

  lsd_dpath #(.CNT_W(CNT_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .curState(curState),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .intFlag(intFlag)
  );
endmodule

// File: tb/line_state_watch_test.sv
module line_state_watch_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sigDetect = 1'b1;
  logic       pairValid = 1'b0;
  logic [4:0] symFirst = '0;
  logic [4:0] symSecond = '0;
  logic [1:0] regAddr = '0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       intFlag;

  always #5 clk = ~clk;

  line_state_watch uut (
    .clk(clk), .rstN(rstN), .sigDetect(sigDetect), .pairValid(pairValid),
    .symFirst(symFirst), .symSecond(symSecond), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .intFlag(intFlag)
  );

  typedef struct {
    bit         isInt;
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t q[$];
  int    checks = 0;
  int    errors = 0;
  bit    finished = 0;

  localparam logic [4:0] Q = 5'b00000, H = 5'b00100, BAD = 5'b00001, DAT = 5'b11110;

  // monitor: pops expected items and compares against the live outputs
  initial forever begin
    item_t it;
    logic [7:0] act;
    wait (q.size() != 0);
    #1;
    it  = q.pop_front();
    act = it.isInt ? {7'd0, intFlag} : regRdData;
    checks++;
    if (act !== it.exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", it.tag, act, it.exp);
    end
  end

  task automatic chk(input logic [1:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    regAddr = a;
    q.push_back('{1'b0, e, t});
    wait (q.size() == 0);
    #2;
  endtask

  task automatic chkInt(input logic e, input string t);
    @(negedge clk);
    q.push_back('{1'b1, {7'd0, e}, t});
    wait (q.size() == 0);
    #2;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic pairs(input logic [4:0] a, input logic [4:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pairValid = 1'b1; symFirst = a; symSecond = b;
    end
    @(negedge clk);
    pairValid = 1'b0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    chk(0, 8'h20, "R12 history after reset");
    chk(1, 8'h00, "R12 mask after reset");
    chk(2, 8'h00, "R12 counter after reset");
    chk(3, 8'h00, "R12 state after reset");

    wr(2, 8'd3);
    chk(0, 8'h00, "R10 reload clears zero bit");

    pairs(Q, Q, 7);
    chk(3, 8'h00, "R1 seven quiet pairs not enough");
    pairs(Q, Q, 1);
    chk(3, 8'h02, "R1 quiet state code");
    chk(0, 8'h42, "R1 quiet and change bits");

    pairs(H, H, 8);
    chk(3, 8'h03, "R2 halt state code");
    chk(0, 8'hC6, "R8 unknown passed on way to halt");

    wr(0, 8'h00);
    chk(0, 8'h00, "R6 zero write clears");

    pairs(H, Q, 8);
    chk(3, 8'h04, "R3 master state code");
    chk(0, 8'hC8, "R3 master history");

    pairs(BAD, BAD, 7);
    chk(3, 8'h00, "R4 fourteen events not enough");
    chk(0, 8'hE8, "R10 counter hit zero");
    pairs(BAD, BAD, 1);
    chk(3, 8'h05, "R4 noise state code");
    chk(0, 8'hF8, "R4 noise history");

    wr(0, 8'h00);
    chk(0, 8'h20, "R10 zero bit survives clear");

    wr(1, 8'h20);
    chk(1, 8'h20, "R9 mask readback");
    chkInt(1'b1, "R11 masked zero bit");
    wr(1, 8'h01);
    chkInt(1'b0, "R11 unmatched mask");

    @(negedge clk); sigDetect = 1'b0;
    chk(3, 8'h01, "R5 no-signal state");
    chk(0, 8'h61, "R5 no-signal bit");
    chkInt(1'b1, "R11 no-signal raises flag");
    @(negedge clk); sigDetect = 1'b1;
    chk(3, 8'h00, "R8 signal return gives unknown");
    chk(0, 8'hE1, "R8 unknown bit");

    wr(0, 8'hFF);
    chk(0, 8'hE1, "R6 ones leave bits");
    wr(0, 8'h7E);
    chk(0, 8'h60, "R6 selective clear");

    wr(2, 8'd5);
    chk(0, 8'h40, "R10 reload clears zero bit");
    chk(2, 8'd5, "R10 counter loaded");
    pairs(BAD, BAD, 1);
    chk(2, 8'd3, "R10 counter decrements by events");
    wr(2, 8'd0);
    chk(0, 8'h60, "R10 zero load sets bit");

    @(negedge clk);
    sigDetect = 1'b0; regWrEn = 1'b1; regAddr = 0; regWrData = 8'h00;
    @(negedge clk);
    regWrEn = 1'b0;
    chk(0, 8'h61, "R6 hardware set beats clear");
    @(negedge clk); sigDetect = 1'b1;
    chk(0, 8'hE1, "R8 unknown after return");

    pairs(Q, Q, 5);
    pairs(DAT, DAT, 1);
    pairs(Q, Q, 7);
    chk(3, 8'h00, "R1 broken run restarts");
    pairs(Q, Q, 1);
    chk(3, 8'h02, "R1 quiet after restart");
    chk(0, 8'hE3, "R1 quiet bit set");

    finished = 1;
    summary();
    $finish;
  end
endmodule